// File: doc/BRIEF.md
# Dual-Channel Indexed Register Port

This block is the host-side register front end of a two-channel asynchronous serial controller. The host sees only four byte locations: a control port and a data port for each of the two channels. Every configuration register of a channel is reached through its single control port. The host first writes a byte that loads a register pointer, then makes one access that uses the pointer. The pointer falls back to zero after that access. The byte that loads the pointer also carries a command field. One command value moves the pointer into the upper bank of eight registers.

From the stored configuration the block decodes the line format of each channel: parity enable, parity sense, stop-bit count and character length. It also works out the bit rate from the 16-bit time constant and the clock-multiplier field. A sequential divider does this work and marks each new result with a one-cycle valid pulse. A software reset, selected by a field in register 9, puts one channel or both back to fixed defaults. Accesses to the data ports are not handled here. They are passed on to the neighbouring interrupt logic as one-cycle strobes.

Top module: `dual_chan_regport`

## Requirements
- R1: Address bit ADDR_SHIFT selects the port, 0 for control and 1 for data. Address bit ADDR_SHIFT+1 selects the channel: index 0 is channel B and index 1 is channel A. The two channels keep separate pointers and separate registers.
- R2: A control write made while the pointer is 0 loads pointer bits 2:0 from data bits 2:0. If data bits 5:3 equal 001, pointer bit 3 is set, which selects registers 8 to 15. Any other value of bits 5:3 leaves pointer bit 3 clear.
- R3: A control write made while the pointer is non-zero updates the selected register and returns the pointer to 0.
- R4: rdata shows the read register selected by the pointer of the addressed channel. A control read clears that pointer to 0.
- R5: After reset, read register 0 reads 0x44, read register 1 reads 0x07, and read registers 12 and 13 read 0x00. The line format is 5 data bits, one stop bit and no parity. Write register 4 resets to 0x04 and write register 5 to 0x00.
- R6: In a write to register 9, data bits 7:6 select a software reset: 01 resets channel B, 10 resets channel A, 11 resets both, and 00 resets nothing. A reset channel returns to the R5 state, including its pointer and its rate. Nothing else in that write is stored.
- R7: A write to register 12 or 13 (time constant low or high byte) is read back unchanged from read register 12 or 13.
- R8: rate = (IN_CLK_HZ/2) / ({WR13,WR12} + 2), then divided by 1, 16, 32 or 64 when WR4 bits 7:6 are 00, 01, 10 or 11, with each division truncating. The result is recomputed after reset, after any write to WR4, WR12 or WR13, and after a software reset. rate_valid pulses for one cycle when the new value is on rate.
- R9: WR4 bit 0 enables parity, and WR4 bit 1 selects even parity. WR4 bits 3:2 equal to 11 selects two stop bits, and any other value selects one. WR5 bits 6:5 set the character length: 00 gives 5 bits, 01 gives 7, 10 gives 6 and 11 gives 8.
- R10: A data-port write or read raises the addressed channel's bit of data_wr_stb or data_rd_stb for exactly the following cycle. A data read returns 0x00. Data accesses leave the pointer unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | ADDR_SHIFT+2 | Byte address: port select at bit ADDR_SHIFT, channel select one bit above it |
| wr_en | input | 1 | Write strobe for this cycle |
| rd_en | input | 1 | Read strobe for this cycle |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for the current address (combinational) |
| data_wr_stb | output | 2 | One-cycle data-write strobe per channel (index 0 = B) |
| data_rd_stb | output | 2 | One-cycle data-read strobe per channel |
| parity_en | output | 2 | Parity enabled, per channel |
| parity_even | output | 2 | Even parity selected, per channel |
| two_stop | output | 2 | Two stop bits selected, per channel |
| data_bits | output | 2x4 | Character length per channel |
| rate | output | 2xRATE_W | Bit rate in bits per second, per channel |
| rate_valid | output | 2 | One-cycle pulse when rate has been updated |

## Verification
The hardest state to reach is a software reset issued from one channel's control port that lands on the other channel while that channel holds a configuration and a half-finished pointer sequence. To reach it, the bench first programs both channels with different time constants and formats. It then leaves a pointer loaded, issues each of the three reset codes from the opposite channel, and reads back through the ports both the reset channel and the untouched one. A behavioural model updated on every clock follows the pointers, the format outputs, the strobes and every rate_valid pulse. The rate corners are the all-ones time constant and the divide-by-64 mode, which truncates the rate to zero.

// File: rtl/dcrp_pkg.sv
package dcrp_pkg;

   typedef logic [7:0] byte_t;

   typedef struct packed {
      logic       par_en;
      logic       par_even;
      logic       stop2;
      logic [3:0] nbits;
   } line_fmt_t;

   localparam byte_t    RD0_RST    = 8'h44;
   localparam byte_t    RD1_RST    = 8'h07;
   localparam byte_t    WR4_RST    = 8'h04;
   localparam logic [2:0] CMD_POINT_HI = 3'b001;
   localparam logic [3:0] IDX_FMT    = 4'd4;
   localparam logic [3:0] IDX_CHAR   = 4'd5;
   localparam logic [3:0] IDX_RESET  = 4'd9;
   localparam logic [3:0] IDX_TC_LO  = 4'd12;
   localparam logic [3:0] IDX_TC_HI  = 4'd13;

   function automatic int unsigned mult_shift(input logic [1:0] mode);
      case (mode)
         2'b00:   return 0;
         2'b01:   return 4;
         2'b10:   return 5;
         default: return 6;
      endcase
   endfunction

endpackage

// File: rtl/dcrp_decode.sv
module dcrp_decode #(
   parameter int ADDR_SHIFT = 0
) (
   input  logic [ADDR_SHIFT+1:0] addr,
   input  logic                  wr_en,
   input  logic                  rd_en,
   output logic [1:0]            ctrl_wr,
   output logic [1:0]            ctrl_rd,
   output logic [1:0]            data_wr,
   output logic [1:0]            data_rd,
   output logic                  sel_ch,
   output logic                  sel_data
);
   logic [1:0] ch_hot;

   assign sel_data = addr[ADDR_SHIFT];
   assign sel_ch   = addr[ADDR_SHIFT+1];
   assign ch_hot   = sel_ch ? 2'b10 : 2'b01;

   always_comb begin
      ctrl_wr = (wr_en && !sel_data) ? ch_hot : 2'b00;
      ctrl_rd = (rd_en && !sel_data) ? ch_hot : 2'b00;
      data_wr = (wr_en &&  sel_data) ? ch_hot : 2'b00;
      data_rd = (rd_en &&  sel_data) ? ch_hot : 2'b00;
   end
endmodule

// File: rtl/dcrp_chan_regs.sv
module dcrp_chan_regs
   import dcrp_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        soft_rst,
   input  logic        ctrl_wr,
   input  logic        ctrl_rd,
   input  byte_t       wdata,
   output byte_t       rdata,
   output logic [1:0]  rst_req,
   output logic        cfg_chg,
   output logic [15:0] tc,
   output logic [1:0]  clk_mode,
   output line_fmt_t   fmt
);
   logic [3:0] ptr_q;
   logic [1:0] mode_q, stop_q, par_q;
   logic [1:0] char_q;
   byte_t      tc_lo_q, tc_hi_q;
   logic       chg_q;
   logic       at_base, reg_wr;

   assign at_base = (ptr_q == 4'd0);
   assign reg_wr  = ctrl_wr && !at_base;
   assign rst_req = (reg_wr && ptr_q == IDX_RESET) ? wdata[7:6] : 2'b00;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ptr_q   <= '0;
         mode_q  <= WR4_RST[7:6];
         stop_q  <= WR4_RST[3:2];
         par_q   <= WR4_RST[1:0];
         char_q  <= '0;
         tc_lo_q <= '0;
         tc_hi_q <= '0;
         chg_q   <= 1'b1;
      end else if (soft_rst) begin
         ptr_q   <= '0;
         mode_q  <= WR4_RST[7:6];
         stop_q  <= WR4_RST[3:2];
         par_q   <= WR4_RST[1:0];
         char_q  <= '0;
         tc_lo_q <= '0;
         tc_hi_q <= '0;
         chg_q   <= 1'b1;
      end else begin
         chg_q <= 1'b0;
         if (ctrl_wr) begin
            if (at_base) begin
               ptr_q <= {wdata[5:3] == CMD_POINT_HI, wdata[2:0]};
            end else begin
               ptr_q <= '0;
               case (ptr_q)
                  IDX_FMT: begin
                     mode_q <= wdata[7:6];
                     stop_q <= wdata[3:2];
                     par_q  <= wdata[1:0];
                     chg_q  <= 1'b1;
                  end
                  IDX_CHAR:  char_q <= wdata[6:5];
                  IDX_TC_LO: begin
                     tc_lo_q <= wdata;
                     chg_q   <= 1'b1;
                  end
                  IDX_TC_HI: begin
                     tc_hi_q <= wdata;
                     chg_q   <= 1'b1;
                  end
                  default: ;
               endcase
            end
         end else if (ctrl_rd) begin
            ptr_q <= '0;
         end
      end
   end

   always_comb begin
      case (ptr_q)
         4'd0:      rdata = RD0_RST;
         4'd1:      rdata = RD1_RST;
         IDX_TC_LO: rdata = tc_lo_q;
         IDX_TC_HI: rdata = tc_hi_q;
         default:   rdata = 8'h00;
      endcase
   end

   always_comb begin
      fmt.par_en   = par_q[0];
      fmt.par_even = par_q[1];
      fmt.stop2    = &stop_q;
      case (char_q)
         2'b00:   fmt.nbits = 4'd5;
         2'b01:   fmt.nbits = 4'd7;
         2'b10:   fmt.nbits = 4'd6;
         default: fmt.nbits = 4'd8;
      endcase
   end

   assign tc       = {tc_hi_q, tc_lo_q};
   assign clk_mode = mode_q;
   assign cfg_chg  = chg_q;

   p_ptr_hi_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_wr && at_base && !soft_rst && wdata[5:3] == 3'b001) |=> ptr_q[3]);
   p_ptr_lo_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_wr && at_base && wdata[5:3] != 3'b001) |=> !ptr_q[3]);
   p_ptr_clr_wr_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_wr && !at_base) |=> ptr_q == 4'd0);
   p_ptr_clr_rd_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_rd && !ctrl_wr) |=> ptr_q == 4'd0);
   p_mirror_lo_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && ptr_q == IDX_TC_LO && !soft_rst) |=> tc[7:0] == $past(wdata));
endmodule

// File: rtl/dcrp_rate_div.sv
module dcrp_rate_div
   import dcrp_pkg::*;
#(
   parameter int unsigned IN_CLK_HZ  = 4915200,
   parameter int          RATE_W     = 32,
   parameter bit          SERIAL_DIV = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [15:0]       tc,
   input  logic [1:0]        clk_mode,
   output logic [RATE_W-1:0] rate,
   output logic              valid
);
   localparam int          CNT_W    = $clog2(RATE_W + 1);
   localparam logic [RATE_W-1:0] DIVIDEND = RATE_W'(IN_CLK_HZ / 2);

   initial begin
      assert (RATE_W >= 2 && RATE_W <= 32 && (IN_CLK_HZ / 2) < (64'd1 << RATE_W))
         else $error("rate width too small for the channel clock");
   end

   generate
      if (SERIAL_DIV) begin : g_seq
         logic              busy_q;
         logic [CNT_W-1:0]  cnt_q;
         logic [RATE_W-1:0] quo_q;
         logic [16:0]       rem_q;
         logic [16:0]       dvs_q;
         logic [1:0]        mode_q;
         logic [17:0]       rem_sh, diff;

         assign rem_sh = {rem_q, quo_q[RATE_W-1]};
         assign diff   = rem_sh - {1'b0, dvs_q};

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               busy_q <= 1'b0;
               cnt_q  <= '0;
               quo_q  <= '0;
               rem_q  <= '0;
               dvs_q  <= '0;
               mode_q <= '0;
               rate   <= '0;
               valid  <= 1'b0;
            end else begin
               valid <= 1'b0;
               if (start) begin
                  busy_q <= 1'b1;
                  cnt_q  <= CNT_W'(RATE_W);
                  quo_q  <= DIVIDEND;
                  rem_q  <= '0;
                  dvs_q  <= {1'b0, tc} + 17'd2;
                  mode_q <= clk_mode;
               end else if (busy_q) begin
                  if (cnt_q != '0) begin
                     cnt_q <= cnt_q - 1'b1;
                     if (!diff[17]) begin
                        rem_q <= diff[16:0];
                        quo_q <= {quo_q[RATE_W-2:0], 1'b1};
                     end else begin
                        rem_q <= rem_sh[16:0];
                        quo_q <= {quo_q[RATE_W-2:0], 1'b0};
                     end
                  end else begin
                     busy_q <= 1'b0;
                     valid  <= 1'b1;
                     rate   <= quo_q >> mult_shift(mode_q);
                  end
               end
            end
         end

         p_one_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
            valid |=> !valid);
         p_restart_r8: assert property (@(posedge clk) disable iff (!rst_n)
            start |=> !valid && busy_q);
      end else begin : g_comb
         logic [RATE_W-1:0] dvs;
         assign dvs = RATE_W'({1'b0, tc} + 17'd2);

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               rate  <= '0;
               valid <= 1'b0;
            end else begin
               valid <= start;
               if (start) rate <= (DIVIDEND / dvs) >> mult_shift(clk_mode);
            end
         end
      end
   endgenerate
endmodule

// File: rtl/dual_chan_regport.sv
module dual_chan_regport
   import dcrp_pkg::*;
#(
   parameter int          ADDR_SHIFT = 0,
   parameter int unsigned IN_CLK_HZ  = 4915200,
   parameter int          RATE_W     = 32,
   parameter bit          SERIAL_DIV = 1'b1
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [ADDR_SHIFT+1:0]  addr,
   input  logic                   wr_en,
   input  logic                   rd_en,
   input  logic [7:0]             wdata,
   output logic [7:0]             rdata,
   output logic [1:0]             data_wr_stb,
   output logic [1:0]             data_rd_stb,
   output logic [1:0]             parity_en,
   output logic [1:0]             parity_even,
   output logic [1:0]             two_stop,
   output logic [1:0][3:0]        data_bits,
   output logic [1:0][RATE_W-1:0] rate,
   output logic [1:0]             rate_valid
);
   localparam int N_CH = 2;

   initial begin
      assert (ADDR_SHIFT >= 0 && ADDR_SHIFT <= 8) else $error("ADDR_SHIFT out of range");
   end

   logic [1:0] ctrl_wr, ctrl_rd, data_wr, data_rd;
   logic       sel_ch, sel_data;
   byte_t      ch_rdata [N_CH];
   logic [1:0] ch_req   [N_CH];
   logic [1:0] soft_rst;

   dcrp_decode #(.ADDR_SHIFT(ADDR_SHIFT)) u_dec (
      .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
      .ctrl_wr(ctrl_wr), .ctrl_rd(ctrl_rd),
      .data_wr(data_wr), .data_rd(data_rd),
      .sel_ch(sel_ch), .sel_data(sel_data)
   );

   assign soft_rst = ch_req[0] | ch_req[1];

   generate
      for (genvar c = 0; c < N_CH; c++) begin : g_ch
         logic [15:0] tc;
         logic [1:0]  mode;
         logic        chg;
         line_fmt_t   fmt;

         dcrp_chan_regs u_regs (
            .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst[c]),
            .ctrl_wr(ctrl_wr[c]), .ctrl_rd(ctrl_rd[c]), .wdata(wdata),
            .rdata(ch_rdata[c]), .rst_req(ch_req[c]), .cfg_chg(chg),
            .tc(tc), .clk_mode(mode), .fmt(fmt)
         );

         dcrp_rate_div #(
            .IN_CLK_HZ(IN_CLK_HZ), .RATE_W(RATE_W), .SERIAL_DIV(SERIAL_DIV)
         ) u_div (
            .clk(clk), .rst_n(rst_n), .start(chg), .tc(tc), .clk_mode(mode),
            .rate(rate[c]), .valid(rate_valid[c])
         );

         assign parity_en[c]   = fmt.par_en;
         assign parity_even[c] = fmt.par_even;
         assign two_stop[c]    = fmt.stop2;
         assign data_bits[c]   = fmt.nbits;

         p_softrst_dflt_r6: assert property (@(posedge clk) disable iff (!rst_n)
            soft_rst[c] |=> !parity_en[c] && !two_stop[c] && data_bits[c] == 4'd5);
      end
   endgenerate

   assign rdata = sel_data ? 8'h00 : ch_rdata[sel_ch];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         data_wr_stb <= '0;
         data_rd_stb <= '0;
      end else begin
         data_wr_stb <= data_wr;
         data_rd_stb <= data_rd;
      end
   end

   p_wstb_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr[ADDR_SHIFT]) |=> data_wr_stb != 2'b00);
   p_onehot_r10: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(data_wr_stb) && $onehot0(data_rd_stb));
endmodule

// File: tb/tb_dual_chan_regport.sv
module tb_dual_chan_regport;
   localparam int IN_HZ = 4915200;
   localparam int CH_HZ = IN_HZ / 2;
   localparam int CW = 0, CR = 1, DW = 2, DR = 3;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic [1:0]      addr = '0;
   logic            wr_en = 1'b0, rd_en = 1'b0;
   logic [7:0]      wdata = '0;
   logic [7:0]      rdata;
   logic [1:0]      data_wr_stb, data_rd_stb, parity_en, parity_even, two_stop, rate_valid;
   logic [1:0][3:0] data_bits;
   logic [1:0][31:0] rate;

   always #4 clk = ~clk;

   dual_chan_regport dut (
      .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
      .wdata(wdata), .rdata(rdata), .data_wr_stb(data_wr_stb),
      .data_rd_stb(data_rd_stb), .parity_en(parity_en), .parity_even(parity_even),
      .two_stop(two_stop), .data_bits(data_bits), .rate(rate), .rate_valid(rate_valid)
   );

   int n_chk = 0, n_fail = 0;
   int m4 [2], m5 [2], mlo [2], mhi [2], mptr [2];
   bit mon_on = 0;
   logic [1:0] exp_ws = '0, exp_rs = '0;

   function automatic void mreset(int c);
      m4[c] = 8'h04; m5[c] = 0; mlo[c] = 0; mhi[c] = 0; mptr[c] = 0;
   endfunction

   function automatic int mrr(int c);
      case (mptr[c])
         0: return 8'h44;
         1: return 8'h07;
         12: return mlo[c];
         13: return mhi[c];
         default: return 0;
      endcase
   endfunction

   function automatic int mrate(int c);
      int sh;
      int v;
      case ((m4[c] >> 6) & 3)
         0: sh = 0;
         1: sh = 4;
         2: sh = 5;
         default: sh = 6;
      endcase
      v = CH_HZ / (mhi[c] * 256 + mlo[c] + 2);
      return v >> sh;
   endfunction

   function automatic int mbits(int c);
      case ((m5[c] >> 5) & 3)
         0: return 5;
         1: return 7;
         2: return 6;
         default: return 8;
      endcase
   endfunction

   task automatic check(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   // expected strobes follow the sampled inputs by one cycle (R10)
   always @(posedge clk) begin
      exp_ws <= (wr_en && addr[0]) ? (2'b01 << addr[1]) : 2'b00;
      exp_rs <= (rd_en && addr[0]) ? (2'b01 << addr[1]) : 2'b00;
   end

   // per-cycle comparison against the behavioural model
   always @(negedge clk) begin
      if (mon_on) begin
         check("R10 write strobe", int'(data_wr_stb), int'(exp_ws));
         check("R10 read strobe", int'(data_rd_stb), int'(exp_rs));
         for (int c = 0; c < 2; c++) begin
            check("R9 parity enable", int'(parity_en[c]), m4[c] & 1);
            check("R9 parity even", int'(parity_even[c]), (m4[c] >> 1) & 1);
            check("R9 stop bits", int'(two_stop[c]), (((m4[c] >> 2) & 3) == 3) ? 1 : 0);
            check("R9 char length", int'(data_bits[c]), mbits(c));
            if (rate_valid[c]) check("R8 rate on valid", int'(rate[c]), mrate(c));
         end
      end
   end

   task automatic op(input int kind, input int c, input int wd, input string req);
      int p;
      int rs;
      @(negedge clk);
      addr  = {c[0], (kind == DW || kind == DR)};
      wr_en = (kind == CW || kind == DW);
      rd_en = (kind == CR || kind == DR);
      wdata = wd[7:0];
      #1;
      if (kind == CR) check(req, int'(rdata), mrr(c));
      if (kind == DR) check(req, int'(rdata), 0);
      @(posedge clk);
      if (kind == CW) begin
         if (mptr[c] == 0) begin
            mptr[c] = (wd & 7) | ((((wd >> 3) & 7) == 1) ? 8 : 0);
         end else begin
            p = mptr[c];
            mptr[c] = 0;
            case (p)
               4: m4[c] = wd & 8'hFF;
               5: m5[c] = wd & 8'hFF;
               12: mlo[c] = wd & 8'hFF;
               13: mhi[c] = wd & 8'hFF;
               9: begin
                  rs = (wd >> 6) & 3;
                  if (rs & 1) mreset(0);
                  if (rs & 2) mreset(1);
               end
               default: ;
            endcase
         end
      end else if (kind == CR) begin
         mptr[c] = 0;
      end
   endtask

   task automatic wreg(input int c, input int r, input int v);
      op(CW, c, (r >= 8) ? (8'h08 | (r & 7)) : r, "");
      op(CW, c, v, "");
   endtask

   task automatic rreg(input int c, input int r, input string req);
      if (r != 0) op(CW, c, (r >= 8) ? (8'h08 | (r & 7)) : r, "");
      op(CR, c, 0, req);
   endtask

   task automatic wait_rate(input int c, input string req);
      bit seen;
      seen = 0;
      for (int i = 0; i < 100 && !seen; i++) begin
         @(negedge clk);
         wr_en = 1'b0;
         rd_en = 1'b0;
         if (rate_valid[c]) seen = 1;
      end
      check(req, int'(seen), 1);
      check(req, int'(rate[c]), mrate(c));
   endtask

   task automatic finish_run;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   endtask

   initial begin
      #(8 * 150000);
      n_fail++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      mreset(0);
      mreset(1);
      repeat (3) @(negedge clk);
      check("R5 reset write strobe", int'(data_wr_stb), 0);
      check("R5 reset char length", int'(data_bits[0]), 5);
      rst_n = 1'b1;
      mon_on = 1;
      // R5 / R8: power-on rate, divide by 1 with constant 0
      wait_rate(0, "R5 R8 reset rate B");
      check("R8 reset rate value", int'(rate[1]), CH_HZ / 2);
      // R5, R4: reset read values and pointer clear after read
      rreg(0, 0, "R5 RR0 after reset");
      rreg(0, 1, "R5 RR1 after reset");
      op(CR, 0, 0, "R4 pointer cleared by read");
      rreg(1, 12, "R5 RR12 after reset");
      rreg(1, 13, "R5 RR13 after reset");
      // R7: time constant mirror, R2 point-high command
      wreg(0, 12, 8'h0E);
      rreg(0, 12, "R7 RR12 mirror");
      wreg(0, 13, 8'h00);
      rreg(0, 13, "R7 RR13 mirror");
      // R9 / R8: x16, two stop bits, even parity
      wreg(0, 4, 8'h4F);
      wait_rate(0, "R8 x16 rate 9600");
      check("R8 expected 9600", int'(rate[0]), 9600);
      // R2: another command code does not select the upper bank
      op(CW, 0, 8'h1C, "");
      op(CR, 0, 0, "R2 non-hi command keeps bank low");
      // R3: after a register write the pointer is back at 0
      wreg(0, 5, 8'h20);
      op(CR, 0, 0, "R3 pointer zero after write");
      // R1: channel independence, pointer held in A not seen by B
      op(CW, 1, 8'h01, "");
      op(CR, 0, 0, "R1 channel B pointer separate");
      op(CR, 1, 0, "R1 channel A RR1");
      wreg(1, 5, 8'h40);
      wreg(1, 5, 8'h60);
      wreg(1, 4, 8'h81);
      wreg(1, 12, 8'hFF);
      wreg(1, 13, 8'hFF);
      wait_rate(1, "R8 all-ones constant x32");
      wreg(1, 4, 8'h03);
      wait_rate(1, "R8 all-ones constant x1");
      check("R8 expected 37", int'(rate[1]), 37);
      wreg(1, 4, 8'hC0);
      wait_rate(1, "R8 x64 truncates to zero");
      // R10: data accesses give strobes and keep the pointer
      op(CW, 0, 8'h01, "");
      op(DW, 1, 8'h55, "");
      op(DR, 0, 0, "R10 data read returns zero");
      op(DW, 0, 8'hAA, "");
      op(CR, 0, 0, "R10 pointer kept across data access");
      // R6: code 00 resets nothing
      wreg(1, 9, 8'h3F);
      rreg(0, 12, "R6 no reset keeps RR12");
      // R6: reset B from channel A while B holds a pointer
      op(CW, 0, 8'h09, "");
      wreg(1, 9, 8'h40);
      op(CR, 0, 0, "R6 B pointer reset");
      rreg(0, 12, "R6 B RR12 reset");
      rreg(1, 13, "R6 A untouched RR13");
      wait_rate(0, "R6 B rate restored");
      // R6: reset A from B
      wreg(0, 9, 8'h80);
      rreg(1, 13, "R6 A RR13 reset");
      wait_rate(1, "R6 A rate restored");
      // R6: both
      wreg(0, 12, 8'h20);
      wreg(1, 13, 8'h01);
      wreg(1, 5, 8'h60);
      wreg(0, 9, 8'hC0);
      rreg(0, 12, "R6 both B RR12");
      rreg(1, 13, "R6 both A RR13");
      wait_rate(0, "R6 both rate");
      repeat (3) @(negedge clk);
      finish_run();
   end
endmodule